// File: doc/BRIEF.md
# Serial-Programmed Frequency Synthesizer Register Interface

This block is a write-only two-wire (I2C) slave that sets up a frequency-synthesizer front end. A host addresses the block, then sends up to four data bytes in a fixed order: an upper divider byte, a lower divider byte, a control byte and a port byte. The block decodes these bytes into parallel register outputs. These outputs are a 15-bit loop divider, a pump-current select, three test bits, a two-bit reference-ratio select, a tuning-output disable, and eight port enables.

The most significant bit of the first data byte sets where the sequence begins. A 0 means the sequence starts at the upper divider byte. A 1 means it starts at the control byte, so the divider is left untouched. Each register is written only when the byte that closes it has been fully received. As a result, the divider outputs never show a mix of old and new halves. Two select pins pick one of four bus addresses, so four of these blocks can share one bus.

SCL and SDA are oversampled on a system clock. The SDA line is open-drain: the block drives it low by asserting an output enable.

Top module: `tuner_prog_slave`

## Requirements
- R1: After reset, the outputs are as follows: divider = 0, pump_hi = 0, test_bits = 3'b001, ref_sel = 2'b00, tune_off = 0, port_on = 0, and SDA is released (sda_oe = 0).
- R2: The block acknowledges an address byte only when its seven upper bits equal {5'b11000, addr_sel[1:0]} and its LSB (the read/write bit) is 0. Any other address is not acknowledged, and the bytes that follow it are neither acknowledged nor stored until the next START.
- R3: Every data byte of an accepted write is acknowledged. sda_oe rises only after an SCL falling edge, at the end of the eighth bit, and it is released at the next SCL falling edge.
- R4: If the first data byte has MSB = 0, the bytes are taken in the order upper divider, lower divider, control, port.
- R5: If the first data byte has MSB = 1, that byte is the control byte, and the next byte is the port byte.
- R6: The divider changes only when the lower divider byte completes. Its new value is {upper[6:0], lower[7:0]}. A transfer that ends after the upper byte leaves the divider unchanged.
- R7: The control byte's bit 6 drives pump_hi, bits 5:3 drive test_bits, bits 2:1 drive ref_sel, and bit 0 drives tune_off. These outputs change only when a control byte completes.
- R8: Bit n of the port byte drives port_on[n]. port_on changes only when a port byte completes.
- R9: Data bytes that arrive after the port byte in the same transfer are acknowledged and change no output.
- R10: A STOP ends the transfer and releases SDA. A repeated START begins address decoding again and selects the entry point again, and any pending upper divider byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| addr_sel | input | 2 | Programmable low address bits |
| sda_oe | output | 1 | When high, the data line is pulled low (acknowledge) |
| div_word | output | 15 | Loop divider value |
| pump_hi | output | 1 | 1 selects high charge-pump current |
| test_bits | output | 3 | Test mode field; 001 means normal operation |
| ref_sel | output | 2 | Reference divider ratio select |
| tune_off | output | 1 | 1 switches the tuning output off |
| port_on | output | 8 | Port output enables, 1 means on |

## Verification
A register commit and the acknowledge drive happen on the same SCL falling edge: the edge that closes the eighth bit of a byte. The bench checks both effects of every byte. It checks the acknowledge level on the wire while SCL is high during the ninth clock. It also compares all register outputs against a behavioural model on every system clock, and the only comparisons it skips are those in a short settling window after that falling edge. Two cases are built specifically to catch an early commit: a STOP that follows the upper divider byte, and a repeated START that follows it. In both, the model shows that the divider must keep its earlier value.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_IGNORE
   } bus_state_e;

   typedef enum logic [2:0] {
      SL_FIRST,
      SL_DIV_LO,
      SL_CTRL,
      SL_PORT,
      SL_DONE
   } slot_e;

   typedef struct packed {
      logic       pump_hi;
      logic [2:0] test;
      logic [1:0] ref_sel;
      logic       tune_off;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{pump_hi: 1'b0, test: 3'b001, ref_sel: 2'b00, tune_off: 1'b0};

endpackage

// File: rtl/tuner_bus_sync.sv
module tuner_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tuner_bus_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
   logic                   scl_q, sda_q;
   logic                   scl_s, sda_s;

   assign scl_s = scl_chain[SYNC_STAGES-1];
   assign sda_s = sda_chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
         sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
         scl_q     <= scl_s;
         sda_q     <= sda_s;
      end
   end

   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tuner_byte_engine.sv
module tuner_byte_engine
   import tuner_pkg::*;
#(
   parameter logic [4:0] ADDR_FIXED = 5'b11000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_lvl,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [1:0] addr_sel,
   output logic       sda_oe,
   output logic       xfer_begin,
   output logic       byte_valid,
   output logic [7:0] byte_data
);

   localparam int BITS = 8;
   localparam int CW   = $clog2(BITS + 1);

   bus_state_e    state;
   logic [CW-1:0] bit_cnt;
   logic [7:0]    shreg;
   logic          full;

   assign full = (bit_cnt == CW'(BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         sda_oe     <= 1'b0;
         xfer_begin <= 1'b0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         xfer_begin <= 1'b0;
         byte_valid <= 1'b0;
         if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise && !full) begin
                     shreg   <= {shreg[6:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && full) begin
                     if (state == ST_ADDR) begin
                        if (shreg == {ADDR_FIXED, addr_sel, 1'b0}) begin
                           sda_oe     <= 1'b1;
                           xfer_begin <= 1'b1;
                           state      <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else begin
                        sda_oe     <= 1'b1;
                        byte_valid <= 1'b1;
                        byte_data  <= shreg;
                        state      <= ST_DATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK, ST_DATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3
   ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall));

   // R2
   nack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> (!sda_oe && !byte_valid));

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
   import tuner_pkg::*;
#(
   parameter int DIV_W  = 15,
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_begin,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic [DIV_W-1:0]  div_q,
   output ctrl_t             ctrl_q,
   output logic [PORT_W-1:0] port_q
);

   localparam int HI_W = DIV_W - 8;

   if (HI_W < 1 || HI_W > 7) begin : g_bad_div
      $error("tuner_reg_bank: DIV_W must lie between 9 and 15");
   end
   if (PORT_W != 8) begin : g_bad_port
      $error("tuner_reg_bank: PORT_W must be 8");
   end

   slot_e           slot;
   logic [HI_W-1:0] div_hi;
   ctrl_t           ctrl_new;

   assign ctrl_new = '{pump_hi: byte_data[6], test: byte_data[5:3],
                       ref_sel: byte_data[2:1], tune_off: byte_data[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot   <= SL_DONE;
         div_hi <= '0;
         div_q  <= '0;
         ctrl_q <= CTRL_RST;
         port_q <= '0;
      end else if (xfer_begin) begin
         slot <= SL_FIRST;
      end else if (byte_valid) begin
         case (slot)
            SL_FIRST: begin
               if (byte_data[7]) begin
                  ctrl_q <= ctrl_new;
                  slot   <= SL_PORT;
               end else begin
                  div_hi <= byte_data[HI_W-1:0];
                  slot   <= SL_DIV_LO;
               end
            end
            SL_DIV_LO: begin
               div_q <= {div_hi, byte_data};
               slot  <= SL_CTRL;
            end
            SL_CTRL: begin
               ctrl_q <= ctrl_new;
               slot   <= SL_PORT;
            end
            SL_PORT: begin
               port_q <= byte_data[PORT_W-1:0];
               slot   <= SL_DONE;
            end
            default: ;
         endcase
      end
   end

   // R6
   div_upper_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && slot == SL_FIRST && !byte_data[7]) |=> $stable(div_q));

   // R6
   div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_q) |-> $past(byte_valid));

   // R7
   ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_q) |-> $past(byte_valid));

   // R8
   port_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_q) |-> $past(byte_valid));

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && slot == SL_DONE) |=> ($stable(port_q) && $stable(ctrl_q) && $stable(div_q)));

endmodule

// File: rtl/tuner_prog_slave.sv
module tuner_prog_slave
   import tuner_pkg::*;
#(
   parameter int         DIV_W       = 15,
   parameter int         PORT_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_FIXED  = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [1:0]        addr_sel,
   output logic              sda_oe,
   output logic [DIV_W-1:0]  div_word,
   output logic              pump_hi,
   output logic [2:0]        test_bits,
   output logic [1:0]        ref_sel,
   output logic              tune_off,
   output logic [PORT_W-1:0] port_on
);

   logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic       xfer_begin, byte_valid;
   logic [7:0] byte_data;
   ctrl_t      ctrl_q;

   tuner_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tuner_byte_engine #(.ADDR_FIXED(ADDR_FIXED)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_lvl    (sda_lvl),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .addr_sel   (addr_sel),
      .sda_oe     (sda_oe),
      .xfer_begin (xfer_begin),
      .byte_valid (byte_valid),
      .byte_data  (byte_data)
   );

   tuner_reg_bank #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_begin (xfer_begin),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .div_q      (div_word),
      .ctrl_q     (ctrl_q),
      .port_q     (port_on)
   );

   assign pump_hi   = ctrl_q.pump_hi;
   assign test_bits = ctrl_q.test;
   assign ref_sel   = ctrl_q.ref_sel;
   assign tune_off  = ctrl_q.tune_off;

endmodule

// File: tb/tb_tuner_prog_slave.sv
`timescale 1ns/1ps
module tb_tuner_prog_slave;

   localparam int H = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_drv = 1'b1;
   logic       sda_drv = 1'b1;
   logic [1:0] addr_sel = 2'b10;
   logic       sda_oe, pump_hi, tune_off;
   logic [14:0] div_word;
   logic [2:0] test_bits;
   logic [1:0] ref_sel;
   logic [7:0] port_on;
   wire        sda_line = sda_drv & ~sda_oe;

   always #2.5 clk = ~clk;

   tuner_prog_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
      .addr_sel(addr_sel), .sda_oe(sda_oe), .div_word(div_word),
      .pump_hi(pump_hi), .test_bits(test_bits), .ref_sel(ref_sel),
      .tune_off(tune_off), .port_on(port_on)
   );

   int total = 0, bad = 0, clk_prints = 0;
   bit settle = 1'b1;

   // behavioural reference model
   logic [14:0] e_div = '0;
   logic        e_pump = 1'b0, e_off = 1'b0;
   logic [2:0]  e_test = 3'b001;
   logic [1:0]  e_ref = 2'b00;
   logic [7:0]  e_port = '0;
   int          m_slot = 4;   // 0 first, 1 lower divider, 2 control, 3 port, 4 done
   logic [6:0]  m_hi = '0;
   bit          m_sel = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !settle) begin
         total++;
         if ({div_word, pump_hi, test_bits, ref_sel, tune_off, port_on} !==
             {e_div, e_pump, e_test, e_ref, e_off, e_port}) begin
            bad++;
            if (clk_prints < 10) begin
               clk_prints++;
               $display("FAIL R6/R7/R8 per-clock actual=%h expected=%h",
                  {div_word, pump_hi, test_bits, ref_sel, tune_off, port_on},
                  {e_div, e_pump, e_test, e_ref, e_off, e_port});
            end
         end
      end
   end

   task automatic half();
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; half(); scl_drv = 1'b1; half();
      sda_drv = 1'b0; half(); scl_drv = 1'b0; half();
      m_sel = 1'b0;
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; half(); scl_drv = 1'b1; half();
      sda_drv = 1'b1; half();
      m_sel = 1'b0;
   endtask

   task automatic model_ctrl(input logic [7:0] b);
      e_pump = b[6]; e_test = b[5:3]; e_ref = b[2:1]; e_off = b[0];
   endtask

   task automatic model_data(input logic [7:0] b);
      case (m_slot)
         0: if (b[7]) begin model_ctrl(b); m_slot = 3; end
            else begin m_hi = b[6:0]; m_slot = 1; end
         1: begin e_div = {m_hi, b}; m_slot = 2; end
         2: begin model_ctrl(b); m_slot = 3; end
         3: begin e_port = b; m_slot = 4; end
         default: ;
      endcase
   endtask

   task automatic xfer_byte(input logic [7:0] b, input bit is_addr, input string tag);
      bit exp_ack;
      exp_ack = is_addr ? (b[7:1] == {5'b11000, addr_sel} && !b[0]) : m_sel;
      for (int i = 7; i >= 0; i--) begin
         sda_drv = b[i]; half(); scl_drv = 1'b1; half(); scl_drv = 1'b0;
      end
      settle = 1'b1;
      sda_drv = 1'b1;
      half();
      if (is_addr) begin
         m_sel = exp_ack;
         if (exp_ack) m_slot = 0;
      end else if (m_sel) begin
         model_data(b);
      end
      settle = 1'b0;
      scl_drv = 1'b1;
      repeat (H/2) @(negedge clk);
      chk(tag, {31'b0, sda_line}, {31'b0, !exp_ack});
      repeat (H/2) @(negedge clk);
      scl_drv = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (10) @(negedge clk);
      // R1 reset state
      chk("R1 div", {17'b0, div_word}, 32'h0);
      chk("R1 pump", {31'b0, pump_hi}, 32'h0);
      chk("R1 test", {29'b0, test_bits}, 32'h1);
      chk("R1 ref", {30'b0, ref_sel}, 32'h0);
      chk("R1 off", {31'b0, tune_off}, 32'h0);
      chk("R1 ports", {24'b0, port_on}, 32'h0);
      chk("R1 sda", {31'b0, sda_oe}, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      settle = 1'b0;

      // R4 full sequence from the divider
      bus_start();
      xfer_byte(8'hC4, 1, "R2 addr ack");
      xfer_byte(8'h2A, 0, "R3 ack div hi");
      xfer_byte(8'h5C, 0, "R3 ack div lo");
      xfer_byte(8'hCE, 0, "R3 ack ctrl");
      xfer_byte(8'hA5, 0, "R3 ack port");
      bus_stop();
      chk("R4 R6 div", {17'b0, div_word}, 32'h2A5C);
      chk("R7 ctrl", {25'b0, pump_hi, test_bits, ref_sel, tune_off}, 32'h4E);
      chk("R8 ports", {24'b0, port_on}, 32'hA5);

      // R5 entry at control
      bus_start();
      xfer_byte(8'hC4, 1, "R2 addr ack");
      xfer_byte(8'hB3, 0, "R5 ack ctrl");
      xfer_byte(8'h3C, 0, "R5 ack port");
      bus_stop();
      chk("R5 div kept", {17'b0, div_word}, 32'h2A5C);
      chk("R5 R7 ctrl", {25'b0, pump_hi, test_bits, ref_sel, tune_off}, 32'h33);
      chk("R5 ports", {24'b0, port_on}, 32'h3C);

      // R6 upper divider byte alone
      bus_start();
      xfer_byte(8'hC4, 1, "R2 addr ack");
      xfer_byte(8'h7F, 0, "R3 ack div hi");
      bus_stop();
      chk("R6 div after upper only", {17'b0, div_word}, 32'h2A5C);
      bus_start();
      xfer_byte(8'hC4, 1, "R2 addr ack");
      xfer_byte(8'h7F, 0, "R3 ack div hi");
      xfer_byte(8'hFF, 0, "R3 ack div lo");
      bus_stop();
      chk("R6 div both", {17'b0, div_word}, 32'h7FFF);

      // R2 wrong address and read bit
      addr_sel = 2'b01;
      bus_start();
      xfer_byte(8'hC4, 1, "R2 wrong addr nack");
      xfer_byte(8'h80, 0, "R2 ignored byte nack");
      xfer_byte(8'h00, 0, "R2 ignored byte nack");
      bus_stop();
      addr_sel = 2'b10;
      bus_start();
      xfer_byte(8'hC5, 1, "R2 read nack");
      xfer_byte(8'h12, 0, "R2 ignored byte nack");
      xfer_byte(8'h34, 0, "R2 ignored byte nack");
      bus_stop();
      chk("R2 div untouched", {17'b0, div_word}, 32'h7FFF);
      chk("R2 ports untouched", {24'b0, port_on}, 32'h3C);

      // R9 bytes past the port byte
      bus_start();
      xfer_byte(8'hC4, 1, "R2 addr ack");
      xfer_byte(8'h8F, 0, "R3 ack ctrl");
      xfer_byte(8'h11, 0, "R3 ack port");
      xfer_byte(8'h00, 0, "R9 extra ack");
      xfer_byte(8'hFF, 0, "R9 extra ack");
      bus_stop();
      chk("R9 ports", {24'b0, port_on}, 32'h11);
      chk("R9 ctrl", {25'b0, pump_hi, test_bits, ref_sel, tune_off}, 32'h0F);

      // R10 repeated START after the upper divider byte
      bus_start();
      xfer_byte(8'hC4, 1, "R2 addr ack");
      xfer_byte(8'h01, 0, "R3 ack div hi");
      bus_start();
      xfer_byte(8'hC4, 1, "R10 re-address ack");
      xfer_byte(8'hC8, 0, "R10 ack ctrl");
      xfer_byte(8'h77, 0, "R10 ack port");
      bus_stop();
      chk("R10 div kept", {17'b0, div_word}, 32'h7FFF);
      chk("R10 ports", {24'b0, port_on}, 32'h77);
      chk("R10 sda released", {31'b0, sda_oe}, 32'h0);

      // R2 another address select value
      addr_sel = 2'b00;
      bus_start();
      xfer_byte(8'hC0, 1, "R2 addr ack sel0");
      xfer_byte(8'h00, 0, "R3 ack div hi");
      xfer_byte(8'h01, 0, "R3 ack div lo");
      bus_stop();
      chk("R2 R4 div sel0", {17'b0, div_word}, 32'h0001);

      half();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule